// File: doc/BRIEF.md
# Banked Interrupt Aggregator with Fast and Normal Request Lines

This block gathers up to forty interrupt sources into five banks of eight bits each. Bank 0 is the fast bank and drives the fast-interrupt line alone. Banks 1 to 4 are normal banks, and any active request in any of them raises the single normal-interrupt line. Each bank has three registers. The status register records which sources are active. The mask register is set by software. The request register is the status ANDed with the mask and can only be read.

Elaboration parameters configure each source in three ways:

- its active pin level (high or low);
- its capture type: edge sources latch until cleared, level sources follow the pin;
- its origin: external pins pass through a two-flop synchroniser, internal sources are sampled directly.

A simple word-addressed port reads and writes the registers. Both output lines are registered and held low while reset is asserted.

Top module: `irq_fanin_ctrl`

## Requirements
- R1: After reset every status, mask and request register reads 0, and both `fiq_o` and `irq_o` are low.
- R2: A request register reads as status AND mask of its bank. Writes to a request address change nothing.
- R3: An edge source sets its status bit when its normalised level goes from inactive to active. The bit then stays set after the source goes inactive. Writing 1 to that bit at the status address clears it, and writing 0 leaves it set.
- R4: A level source's status bit follows its normalised level. Writing 1 to it has no effect.
- R5: A source configured active-low (bit set in `SRC_ACT_LOW`) counts as active while its pin is 0.
- R6: An external source passes through two synchroniser flops. Its status bit updates on the third rising clock edge after the pin changes, and the output line updates on the fourth. An internal source updates status on the first edge and the output on the second.
- R7: `fiq_o` is high one cycle after any request bit of bank 0 is high, and low one cycle after none is high.
- R8: `irq_o` is high one cycle after any request bit of banks 1 to 4 is high, and low one cycle after none is high.
- R9: Bank b occupies word addresses 3b (status), 3b+1 (request) and 3b+2 (mask). Address 15 reads 0 and ignores writes. Masks change only through a write to their own address.
- R10: When an edge source's rising transition and a write-1 clear of the same bit fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pin | input | 40 | Source inputs, bit 8b+i is source i of bank b |
| bus_addr | input | 4 | Word address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| fiq_o | output | 1 | Registered fast-interrupt request |
| irq_o | output | 1 | Registered normal-interrupt request |

## Verification
A bad status bit shows up within one read at the status address, and it reaches an output line one cycle after a matching mask bit is set. The bench therefore pairs every register read with a check of the output line at its exact cycle. A wrong mask or address decode shows up as the wrong value at a neighbouring address. A missing or extra synchroniser stage moves the output edge by a whole cycle, so external-path latencies are checked on the exact edge and not after a settling wait. A lost set-over-clear priority leaves the status bit reading 0 straight after the colliding write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_REQ  = 2'd1,
    REG_MASK = 2'd2,
    REG_NONE = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic      valid;
    logic [7:0] bank;
    reg_kind_e kind;
  } reg_sel_t;

  // Each bank takes three consecutive words: status, request, mask.
  function automatic reg_sel_t decode_word(input logic [7:0] addr, input int unsigned nbank);
    reg_sel_t    s;
    int unsigned a;
    a       = int'(addr);
    s.valid = (a < 3 * nbank);
    s.bank  = 8'(a / 3);
    s.kind  = s.valid ? reg_kind_e'(2'(a % 3)) : REG_NONE;
    return s;
  endfunction

  function automatic logic [7:0] masked_req(input logic [7:0] stat, input logic [7:0] msk);
    return stat & msk;
  endfunction

endpackage

// File: rtl/irqc_src_cond.sv
module irqc_src_cond #(
  parameter int            N       = 40,
  parameter logic [N-1:0]  ACT_LOW = '0,
  parameter logic [N-1:0]  EXT_SEL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] cond
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic raw;
    if (EXT_SEL[i]) begin : g_ext
      logic s1_q, s2_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q <= ACT_LOW[i];
          s2_q <= ACT_LOW[i];
        end else begin
          s1_q <= pin[i];
          s2_q <= s1_q;
        end
      end
      assign raw = s2_q;
    end else begin : g_int
      assign raw = pin[i];
    end
    assign cond[i] = raw ^ ACT_LOW[i];
  end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int            BW       = 8,
  parameter logic [BW-1:0] EDGE_SEL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] cond,
  input  logic [BW-1:0] clr,
  input  logic          mask_we,
  input  logic [BW-1:0] mask_wdata,
  output logic [BW-1:0] status,
  output logic [BW-1:0] mask,
  output logic [BW-1:0] req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  for (genvar i = 0; i < BW; i++) begin : g_bit
    if (EDGE_SEL[i]) begin : g_edge
      logic prev_q;
      logic rise;
      assign rise = cond[i] & ~prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q    <= 1'b0;
          status[i] <= 1'b0;
        end else begin
          prev_q    <= cond[i];
          status[i] <= rise | (status[i] & ~clr[i]);
        end
      end
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status[i] <= 1'b0;
        else        status[i] <= cond[i];
      end
    end
  end

  if (BW == 8) begin : g_req8
    assign req = masked_req(status, mask);
  end else begin : g_reqn
    assign req = status & mask;
  end

endmodule

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl
  import irqc_pkg::*;
#(
  parameter int                    NBANK       = 5,
  parameter int                    BW          = 8,
  parameter logic [NBANK*BW-1:0]   SRC_ACT_LOW = 40'h00_00_00_F0_00,
  parameter logic [NBANK*BW-1:0]   SRC_EDGE    = 40'h0F_0F_0F_0F_0F,
  parameter logic [NBANK*BW-1:0]   SRC_EXT     = 40'hFF_FF_FF_FF_07,
  localparam int                   NSRC        = NBANK * BW,
  localparam int                   AW          = $clog2(3 * NBANK + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pin,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [BW-1:0]   bus_wdata,
  output logic [BW-1:0]   bus_rdata,
  output logic            fiq_o,
  output logic            irq_o
);

  logic [NSRC-1:0]  cond_vec;
  logic [NSRC-1:0]  status_vec;
  logic [NSRC-1:0]  mask_vec;
  logic [NSRC-1:0]  req_vec;
  logic [NSRC-1:0]  clr_vec;
  logic [NBANK-1:0] mask_we;
  logic [NBANK-1:0] bank_any;
  logic             fiq_next;
  logic             irq_next;
  reg_sel_t         sel;

  irqc_src_cond #(
    .N       (NSRC),
    .ACT_LOW (SRC_ACT_LOW),
    .EXT_SEL (SRC_EXT)
  ) u_cond (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (src_pin),
    .cond  (cond_vec)
  );

  always_comb sel = decode_word(8'(bus_addr), NBANK);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = bus_wr && sel.valid && (int'(sel.bank) == b);
    assign clr_vec[b*BW +: BW] = (hit && sel.kind == REG_STAT) ? bus_wdata : '0;
    assign mask_we[b]          = hit && (sel.kind == REG_MASK);

    irqc_bank #(
      .BW       (BW),
      .EDGE_SEL (SRC_EDGE[b*BW +: BW])
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .cond       (cond_vec[b*BW +: BW]),
      .clr        (clr_vec[b*BW +: BW]),
      .mask_we    (mask_we[b]),
      .mask_wdata (bus_wdata),
      .status     (status_vec[b*BW +: BW]),
      .mask       (mask_vec[b*BW +: BW]),
      .req        (req_vec[b*BW +: BW])
    );

    assign bank_any[b] = |req_vec[b*BW +: BW];
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (sel.valid && int'(sel.bank) == b) begin
        case (sel.kind)
          REG_STAT: bus_rdata = status_vec[b*BW +: BW];
          REG_REQ:  bus_rdata = req_vec[b*BW +: BW];
          REG_MASK: bus_rdata = mask_vec[b*BW +: BW];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  assign fiq_next = bank_any[0];
  assign irq_next = |bank_any[NBANK-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      fiq_o <= fiq_next;
      irq_o <= irq_next;
    end
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int                  NBANK    = 5,
  parameter int                  BW       = 8,
  parameter logic [NBANK*BW-1:0] EDGE_SEL = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NBANK*BW-1:0] status_vec,
  input logic [NBANK*BW-1:0] mask_vec,
  input logic [NBANK*BW-1:0] req_vec,
  input logic [NBANK*BW-1:0] clr_vec,
  input logic [NBANK-1:0]    mask_we,
  input logic                fiq_o,
  input logic                irq_o
);

  localparam int NSRC = NBANK * BW;

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!fiq_o && !irq_o)); // R1

  AST_REQ_WITHIN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vec & ~status_vec) == '0); // R2

  AST_FIQ_FOLLOWS_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == $past(|req_vec[BW-1:0])); // R7

  AST_IRQ_FOLLOWS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|req_vec[NSRC-1:BW])); // R8

  AST_MASK_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_vec) |-> $past(|mask_we)); // R9

  for (genvar k = 0; k < NSRC; k++) begin : g_edge_chk
    if (EDGE_SEL[k]) begin : g_on
      AST_EDGE_HELD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_vec[k]) |-> $past(clr_vec[k])); // R3
    end
  end

endmodule

bind irq_fanin_ctrl irqc_checker #(
  .NBANK    (NBANK),
  .BW       (BW),
  .EDGE_SEL (SRC_EDGE)
) u_irqc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .status_vec (status_vec),
  .mask_vec   (mask_vec),
  .req_vec    (req_vec),
  .clr_vec    (clr_vec),
  .mask_we    (mask_we),
  .fiq_o      (fiq_o),
  .irq_o      (irq_o)
);

// File: tb/irq_fanin_ctrl_bench.sv
module irq_fanin_ctrl_bench;

  localparam int CLK_P = 10;
  localparam logic [39:0] IDLE_PINS = 40'h00_00_00_F0_00; // active-low pins idle high

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] src_pin = IDLE_PINS;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        fiq_o, irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_fanin_ctrl u_irq_fanin_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pin   (src_pin),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .fiq_o     (fiq_o),
    .irq_o     (irq_o)
  );

  function automatic logic [3:0] waddr(int bank, int kind); // kind 0 stat, 1 req, 2 mask
    return 4'(bank * 3 + kind);
  endfunction

  task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_pin = IDLE_PINS; bus_wr = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    do_reset();
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), d);
      check("R1", $sformatf("reg %0d after reset", a), d, 8'h00);
    end
    check("R1", "fiq after reset", {7'd0, fiq_o}, 8'h00);
    check("R1", "irq after reset", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_external_edge();
    logic [7:0] d;
    do_reset();
    wr(waddr(2, 2), 8'h01);
    src_pin[16] = 1'b1;
    tick(2);
    rd(waddr(2, 0), d); check("R6", "status after 2 edges", d, 8'h00);
    tick(1);
    rd(waddr(2, 0), d); check("R6", "status after 3 edges", d, 8'h01);
    check("R6", "irq after 3 edges", {7'd0, irq_o}, 8'h00);
    tick(1);
    check("R6", "irq after 4 edges", {7'd0, irq_o}, 8'h01);
    check("R8", "fiq stays low", {7'd0, fiq_o}, 8'h00);
    src_pin[16] = 1'b0;
    tick(5);
    rd(waddr(2, 0), d); check("R3", "edge bit held", d, 8'h01);
    wr(waddr(2, 0), 8'h00);
    rd(waddr(2, 0), d); check("R3", "write 0 keeps bit", d, 8'h01);
    wr(waddr(2, 0), 8'h01);
    rd(waddr(2, 0), d); check("R3", "write 1 clears bit", d, 8'h00);
    check("R8", "irq one cycle after clear", {7'd0, irq_o}, 8'h01);
    tick(1);
    check("R8", "irq drops after clear", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_request_read_only();
    logic [7:0] d;
    do_reset();
    src_pin[33] = 1'b1;
    tick(5);
    rd(waddr(4, 0), d); check("R2", "status bank4", d, 8'h02);
    rd(waddr(4, 1), d); check("R2", "request masked off", d, 8'h00);
    check("R8", "irq low while masked", {7'd0, irq_o}, 8'h00);
    wr(waddr(4, 1), 8'hFF);
    rd(waddr(4, 1), d); check("R2", "request write ignored", d, 8'h00);
    rd(waddr(4, 2), d); check("R2", "mask unchanged by request write", d, 8'h00);
    wr(waddr(4, 2), 8'h06);
    rd(waddr(4, 1), d); check("R2", "request = status & mask", d, 8'h02);
    tick(1);
    check("R8", "irq from bank 4", {7'd0, irq_o}, 8'h01);
  endtask

  task automatic t_level();
    logic [7:0] d;
    do_reset();
    src_pin[28] = 1'b1;
    tick(4);
    rd(waddr(3, 0), d); check("R4", "level bit set", d, 8'h10);
    wr(waddr(3, 0), 8'h10);
    rd(waddr(3, 0), d); check("R4", "clear ignored on level", d, 8'h10);
    src_pin[28] = 1'b0;
    tick(4);
    rd(waddr(3, 0), d); check("R4", "level bit follows pin", d, 8'h00);
  endtask

  task automatic t_active_low();
    logic [7:0] d;
    do_reset();
    rd(waddr(1, 0), d); check("R5", "idle-high pin inactive", d, 8'h00);
    src_pin[13] = 1'b0;
    tick(4);
    rd(waddr(1, 0), d); check("R5", "low pin active", d, 8'h20);
    wr(waddr(1, 2), 8'h20);
    tick(1);
    check("R5", "irq from active-low source", {7'd0, irq_o}, 8'h01);
    src_pin[13] = 1'b1;
    tick(4);
    rd(waddr(1, 0), d); check("R5", "high pin inactive", d, 8'h00);
    check("R8", "irq released", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_fast_internal();
    logic [7:0] d;
    do_reset();
    wr(waddr(0, 2), 8'h10);
    src_pin[4] = 1'b1;
    tick(1);
    rd(waddr(0, 0), d); check("R6", "internal status after 1 edge", d, 8'h10);
    check("R7", "fiq not yet", {7'd0, fiq_o}, 8'h00);
    tick(1);
    check("R7", "fiq raised", {7'd0, fiq_o}, 8'h01);
    check("R7", "irq untouched by fast bank", {7'd0, irq_o}, 8'h00);
    src_pin[4] = 1'b0;
    tick(2);
    check("R7", "fiq released", {7'd0, fiq_o}, 8'h00);
  endtask

  task automatic t_set_beats_clear();
    logic [7:0] d;
    do_reset();
    src_pin[3] = 1'b1;
    tick(1);
    src_pin[3] = 1'b0;
    tick(1);
    rd(waddr(0, 0), d); check("R10", "internal edge latched", d, 8'h08);
    bus_addr = waddr(0, 0); bus_wdata = 8'h08; bus_wr = 1'b1; src_pin[3] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    rd(waddr(0, 0), d); check("R10", "set wins over clear", d, 8'h08);
    wr(waddr(0, 0), 8'h08);
    rd(waddr(0, 0), d); check("R3", "clear with source held", d, 8'h00);
  endtask

  task automatic t_address_map();
    logic [7:0] d;
    do_reset();
    for (int b = 0; b < 5; b++) wr(waddr(b, 2), 8'(8'h21 + b));
    wr(4'd15, 8'hFF);
    rd(4'd15, d); check("R9", "unused word reads 0", d, 8'h00);
    for (int b = 0; b < 5; b++) begin
      rd(waddr(b, 2), d); check("R9", $sformatf("mask bank %0d", b), d, 8'(8'h21 + b));
      rd(waddr(b, 0), d); check("R9", $sformatf("status bank %0d", b), d, 8'h00);
      rd(waddr(b, 1), d); check("R9", $sformatf("request bank %0d", b), d, 8'h00);
    end
  endtask

  initial begin
    t_reset_state();
    t_external_edge();
    t_request_read_only();
    t_level();
    t_active_low();
    t_fast_internal();
    t_set_beats_clear();
    t_address_map();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule